// File: doc/BRIEF.md
# Block-Floating-Point Radix-2 Butterfly

This block is the arithmetic core of a fixed-point radix-2 FFT engine. Each valid cycle it accepts two complex operands A and B of DW signed bits and a complex twiddle W in Q1.(DW-1) format. It returns X = A + W·B and Y = A − W·B at DW+1 bits, so no result is truncated or wrapped. The twiddle product uses four real multipliers and is rounded back to DW bits. Two real add/subtract operations form the product and four more form the sum and difference. The pipeline is three registers deep, and a valid bit travels with the data.

Scaling is decided once per pass. A sticky flag collects every result that does not fit in DW signed bits. When the pass closes, the flag is copied into a scale-enable register. During the following pass every A and B component is halved with rounding before it is used. A block exponent counts the passes that ran halved.

The surrounding engine supplies the operand stream and marks frame start, pass start and pass end. It reads the exponent together with the final pass's outputs. Memory, addressing, twiddle generation and reordering sit outside this block.

Top module: `bfp_butterfly`

## Requirements
- R1: While reset is held and after it is released with no stimulus, out_valid_o, ovf_o and scale_o are 0 and blk_exp_o is 0.
- R2: With scaling off, x = a + t and y = a − t for real and imaginary parts, where t_re = round(b_re·w_re − b_im·w_im) and t_im = round(b_re·w_im + b_im·w_re). Rounding means add 2^(DW−2), then arithmetic shift right by DW−1. Results are signed DW+1 bits with no truncation.
- R3: The results and out_valid_o appear after the third rising edge, counting the edge that samples the inputs. A cycle with in_valid_i low gives out_valid_o low three edges later.
- R4: ovf_o is 1, together with out_valid_o, exactly when at least one of the four results of that cycle lies outside the signed DW-bit range.
- R5: pass_start_i clears the sticky overflow record. pass_end_i loads scale_o with the OR of all overflows seen since pass start. Operands inside a pass use the scale value set at the previous pass end, not the pass's own overflows.
- R6: While scale_o is 1, each of a_re, a_im, b_re and b_im is replaced by (v + 1) >>> 1 before use. The twiddle is not scaled.
- R7: On pass_end_i, blk_exp_o increments by one if scale_o was 1 during that pass, and otherwise it holds. frame_start_i clears blk_exp_o, scale_o and the sticky record.
- R8: A rounded twiddle product outside the DW-bit range is clamped to −2^(DW−1) or 2^(DW−1)−1, never wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| frame_start_i | input | 1 | Frame start strobe |
| pass_start_i | input | 1 | Pass start strobe |
| pass_end_i | input | 1 | Pass end strobe |
| in_valid_i | input | 1 | Operand valid |
| a_re_i | input | DW | Operand A real |
| a_im_i | input | DW | Operand A imaginary |
| b_re_i | input | DW | Operand B real |
| b_im_i | input | DW | Operand B imaginary |
| w_re_i | input | DW | Twiddle real, Q1.(DW-1) |
| w_im_i | input | DW | Twiddle imaginary, Q1.(DW-1) |
| out_valid_o | output | 1 | Result valid |
| x_re_o | output | DW+1 | Sum real |
| x_im_o | output | DW+1 | Sum imaginary |
| y_re_o | output | DW+1 | Difference real |
| y_im_o | output | DW+1 | Difference imaginary |
| ovf_o | output | 1 | Result exceeds DW bits |
| scale_o | output | 1 | Halving applied in current pass |
| blk_exp_o | output | EW | Block exponent |

## Verification
The bench drives one operand set per cycle on the falling edge. The set driven at falling edge k is compared on falling edge k+3, after the three pipeline registers have loaded it. That comparison covers the valid bit, all four results and the overflow flag, including bubble cycles. The scale and exponent registers change on the edge that samples a strobe. They are therefore read on the falling edge right after the strobe has been driven and sampled. Each pass ends only after its last result has been compared, so every overflow is already in the sticky record when pass end arrives.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    // Number of real components in the two complex operands A and B.
    localparam int unsigned NUM_OPS = 4;
    // Indices into the operand array.
    localparam int unsigned OP_ARE = 0;
    localparam int unsigned OP_AIM = 1;
    localparam int unsigned OP_BRE = 2;
    localparam int unsigned OP_BIM = 3;
    // Number of twiddle partial products.
    localparam int unsigned NUM_PROD = 4;
endpackage

// File: rtl/bfp_prescale.sv
module bfp_prescale
    import bfp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 vld_i,
    input  logic                 scale_i,
    input  logic signed [DW-1:0] op_i [NUM_OPS],
    input  logic signed [DW-1:0] wre_i,
    input  logic signed [DW-1:0] wim_i,
    output logic                 vld_o,
    output logic signed [DW-1:0] op_o [NUM_OPS],
    output logic signed [DW-1:0] wre_o,
    output logic signed [DW-1:0] wim_o
);
    localparam int HB = 2 ** (DW - 2);

    typedef struct packed {
        logic                        vld;
        logic [NUM_OPS-1:0][DW-1:0]  op;
        logic [DW-1:0]               wre;
        logic [DW-1:0]               wim;
    } st_t;

    st_t st_d, st_q;
    logic signed [DW-1:0] half [NUM_OPS];

    // Rounded halving: (v + 1) >>> 1, done at DW+1 bits so +1 cannot wrap.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_half
        logic signed [DW:0] ext;
        assign ext     = {op_i[g][DW-1], op_i[g]} + {{DW{1'b0}}, 1'b1};
        assign half[g] = DW'(ext >>> 1);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        for (int i = 0; i < NUM_OPS; i++) begin
            st_d.op[i] = scale_i ? half[i] : op_i[i];
        end
        st_d.wre = wre_i;
        st_d.wim = wim_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign wre_o = st_q.wre;
    assign wim_o = st_q.wim;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_out
        assign op_o[g] = st_q.op[g];
        // R6: a halved operand always lies within half of the input range.
        a_r6_half_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (vld_i && scale_i) |=> ((op_o[g] <= HB) && (op_o[g] >= -HB)));
    end
endmodule

// File: rtl/bfp_twmul.sv
module bfp_twmul
    import bfp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   vld_i,
    input  logic signed [DW-1:0]   op_i [NUM_OPS],
    input  logic signed [DW-1:0]   wre_i,
    input  logic signed [DW-1:0]   wim_i,
    output logic                   vld_o,
    output logic signed [DW-1:0]   are_o,
    output logic signed [DW-1:0]   aim_o,
    output logic signed [2*DW-1:0] prod_o [NUM_PROD]
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic                       vld;
        logic [DW-1:0]              are;
        logic [DW-1:0]              aim;
        logic [NUM_PROD-1:0][PW-1:0] prod;
    } st_t;

    st_t st_d, st_q;
    logic signed [PW-1:0] prod [NUM_PROD];

    // Product g: bit 1 picks b_im over b_re, bit 0 picks w_im over w_re.
    // g0 = br*wr, g1 = br*wi, g2 = bi*wr, g3 = bi*wi
    for (genvar g = 0; g < NUM_PROD; g++) begin : g_mul
        logic signed [DW-1:0] mb, mw;
        assign mb = g[1] ? op_i[OP_BIM] : op_i[OP_BRE];
        assign mw = g[0] ? wim_i : wre_i;
        assign prod[g] = $signed({{DW{mb[DW-1]}}, mb}) * $signed({{DW{mw[DW-1]}}, mw});
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        st_d.are = op_i[OP_ARE];
        st_d.aim = op_i[OP_AIM];
        for (int i = 0; i < NUM_PROD; i++) begin
            st_d.prod[i] = prod[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign are_o = st_q.are;
    assign aim_o = st_q.aim;
    for (genvar g = 0; g < NUM_PROD; g++) begin : g_out
        assign prod_o[g] = st_q.prod[g];
    end
endmodule

// File: rtl/bfp_sumdiff.sv
module bfp_sumdiff
    import bfp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   vld_i,
    input  logic signed [DW-1:0]   are_i,
    input  logic signed [DW-1:0]   aim_i,
    input  logic signed [2*DW-1:0] prod_i [NUM_PROD],
    output logic                   vld_o,
    output logic signed [DW:0]     xre_o,
    output logic signed [DW:0]     xim_o,
    output logic signed [DW:0]     yre_o,
    output logic signed [DW:0]     yim_o,
    output logic                   ovf_o
);
    localparam int FW = 2 * DW + 1;
    localparam logic signed [FW-1:0] RND  = FW'(2 ** (DW - 2));
    localparam logic signed [FW-1:0] MAXF = FW'(2 ** (DW - 1) - 1);
    localparam logic signed [FW-1:0] MINF = -MAXF - 1;

    typedef struct packed {
        logic                vld;
        logic                ovf;
        logic [3:0][DW:0]    res;
    } st_t;

    st_t st_d, st_q;
    logic signed [FW-1:0] pe [NUM_PROD];
    logic signed [DW-1:0] tw [2];
    logic signed [DW-1:0] av [2];
    logic signed [DW:0]   sum [2];
    logic signed [DW:0]   dif [2];

    for (genvar g = 0; g < NUM_PROD; g++) begin : g_ext
        assign pe[g] = {prod_i[g][2*DW-1], prod_i[g]};
    end

    assign av[0] = are_i;
    assign av[1] = aim_i;

    // c = 0: real part (br*wr - bi*wi); c = 1: imaginary part (br*wi + bi*wr).
    for (genvar c = 0; c < 2; c++) begin : g_cmp
        logic signed [FW-1:0] full, rnd;
        if (c == 0) begin : g_re
            assign full = pe[0] - pe[3];
        end else begin : g_im
            assign full = pe[1] + pe[2];
        end
        assign rnd = (full + RND) >>> (DW - 1);
        // R8: saturate to DW bits instead of wrapping
        assign tw[c] = (rnd > MAXF) ? DW'(MAXF) :
                       (rnd < MINF) ? DW'(MINF) : DW'(rnd);
        assign sum[c] = {av[c][DW-1], av[c]} + {tw[c][DW-1], tw[c]};
        assign dif[c] = {av[c][DW-1], av[c]} - {tw[c][DW-1], tw[c]};
    end

    always_comb begin
        st_d        = st_q;
        st_d.vld    = vld_i;
        st_d.res[0] = sum[0];
        st_d.res[1] = sum[1];
        st_d.res[2] = dif[0];
        st_d.res[3] = dif[1];
        st_d.ovf    = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (st_d.res[i][DW] != st_d.res[i][DW-1]) st_d.ovf = vld_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign ovf_o = st_q.ovf;
    assign xre_o = st_q.res[0];
    assign xim_o = st_q.res[1];
    assign yre_o = st_q.res[2];
    assign yim_o = st_q.res[3];

    // R4: an overflow indication is only ever given with a valid result
    a_r4_ovf_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> vld_o);
endmodule

// File: rtl/bfp_scale_ctrl.sv
module bfp_scale_ctrl #(
    parameter int EW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          frame_start_i,
    input  logic          pass_start_i,
    input  logic          pass_end_i,
    input  logic          res_vld_i,
    input  logic          res_ovf_i,
    output logic          scale_o,
    output logic [EW-1:0] exp_o
);
    localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};

    typedef struct packed {
        logic          sticky;
        logic          scale;
        logic [EW-1:0] expn;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    assign hit = res_vld_i & res_ovf_i;

    always_comb begin
        st_d = st_q;
        if (hit)          st_d.sticky = 1'b1;
        if (pass_start_i) st_d.sticky = 1'b0;
        if (pass_end_i) begin
            st_d.scale = st_q.sticky | hit;
            if (st_q.scale && (st_q.expn != EXP_MAX)) st_d.expn = st_q.expn + 1'b1;
        end
        if (frame_start_i) st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign scale_o = st_q.scale;
    assign exp_o   = st_q.expn;

    // R5: the scale decision only moves at a pass boundary or frame start
    a_r5_scale_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pass_end_i && !frame_start_i) |=> $stable(scale_o));
    // R7: the exponent never goes down inside a frame
    a_r7_exp_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start_i |=> (exp_o >= $past(exp_o)));
    // R7: frame start returns exponent and scale to zero
    a_r7_frame_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_i |=> ((exp_o == '0) && !scale_o));
endmodule

// File: rtl/bfp_butterfly.sv
module bfp_butterfly
    import bfp_pkg::*;
#(
    parameter int DW = 16,
    parameter int EW = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 frame_start_i,
    input  logic                 pass_start_i,
    input  logic                 pass_end_i,
    input  logic                 in_valid_i,
    input  logic signed [DW-1:0] a_re_i,
    input  logic signed [DW-1:0] a_im_i,
    input  logic signed [DW-1:0] b_re_i,
    input  logic signed [DW-1:0] b_im_i,
    input  logic signed [DW-1:0] w_re_i,
    input  logic signed [DW-1:0] w_im_i,
    output logic                 out_valid_o,
    output logic signed [DW:0]   x_re_o,
    output logic signed [DW:0]   x_im_o,
    output logic signed [DW:0]   y_re_o,
    output logic signed [DW:0]   y_im_o,
    output logic                 ovf_o,
    output logic                 scale_o,
    output logic [EW-1:0]        blk_exp_o
);
    logic signed [DW-1:0]   op_in [NUM_OPS];
    logic signed [DW-1:0]   op_s1 [NUM_OPS];
    logic signed [DW-1:0]   wre_s1, wim_s1;
    logic                   vld_s1, vld_s2;
    logic signed [DW-1:0]   are_s2, aim_s2;
    logic signed [2*DW-1:0] prod_s2 [NUM_PROD];

    assign op_in[OP_ARE] = a_re_i;
    assign op_in[OP_AIM] = a_im_i;
    assign op_in[OP_BRE] = b_re_i;
    assign op_in[OP_BIM] = b_im_i;

    bfp_prescale #(.DW(DW)) u_prescale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (in_valid_i),
        .scale_i(scale_o),
        .op_i   (op_in),
        .wre_i  (w_re_i),
        .wim_i  (w_im_i),
        .vld_o  (vld_s1),
        .op_o   (op_s1),
        .wre_o  (wre_s1),
        .wim_o  (wim_s1)
    );

    bfp_twmul #(.DW(DW)) u_twmul (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (vld_s1),
        .op_i   (op_s1),
        .wre_i  (wre_s1),
        .wim_i  (wim_s1),
        .vld_o  (vld_s2),
        .are_o  (are_s2),
        .aim_o  (aim_s2),
        .prod_o (prod_s2)
    );

    bfp_sumdiff #(.DW(DW)) u_sumdiff (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (vld_s2),
        .are_i  (are_s2),
        .aim_i  (aim_s2),
        .prod_i (prod_s2),
        .vld_o  (out_valid_o),
        .xre_o  (x_re_o),
        .xim_o  (x_im_o),
        .yre_o  (y_re_o),
        .yim_o  (y_im_o),
        .ovf_o  (ovf_o)
    );

    bfp_scale_ctrl #(.EW(EW)) u_scale_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .frame_start_i(frame_start_i),
        .pass_start_i (pass_start_i),
        .pass_end_i   (pass_end_i),
        .res_vld_i    (out_valid_o),
        .res_ovf_i    (ovf_o),
        .scale_o      (scale_o),
        .exp_o        (blk_exp_o)
    );

    // R3: a sampled operand set emerges three edges later, a bubble stays a bubble
    a_r3_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |-> ##3 out_valid_o);
    a_r3_bubble_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |-> ##3 !out_valid_o);
endmodule

// File: tb/bfp_butterfly_bench.sv
`timescale 1ns/1ps
module bfp_butterfly_bench;
    localparam int DW   = 16;
    localparam int EW   = 4;
    localparam int NV   = 9;
    localparam int MAXV = 2 ** (DW - 1) - 1;
    localparam int MINV = -(2 ** (DW - 1));

    // Columns: a_re, a_im, b_re, b_im, w_re, w_im, in_valid
    // Rows 0..6: ordinary pass (row 3 is a bubble); rows 7..8: overflow pass.
    localparam int TV [NV][7] = '{
        '{  1000,  -2000,   3000,    400,  16384,      0, 1},
        '{     0,      0,    100,   -100,      0,  32767, 1},
        '{ -5000,   7000,  12000,  -8000,  23170, -23170, 1},
        '{   111,    222,    333,    444,    555,    666, 0},
        '{    -1,      1,     -1,      1, -32768,  32767, 1},
        '{ 10000, -10000,  -9000,   9000,  32767,  32767, 1},
        '{-32768,  32767,      0,      0,  12345, -12345, 1},
        '{ 32767, -32768, -32768, -32768, -32768,      0, 1},
        '{   100,    200,    300,    400,      0,      0, 1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic frame_start, pass_start, pass_end, in_valid;
    logic signed [DW-1:0] a_re, a_im, b_re, b_im, w_re, w_im;
    logic out_valid, ovf, scale;
    logic signed [DW:0] x_re, x_im, y_re, y_im;
    logic [EW-1:0] blk_exp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bfp_butterfly #(.DW(DW), .EW(EW)) u_bfp_butterfly (
        .clk_i(clk), .rst_ni(rst_n),
        .frame_start_i(frame_start), .pass_start_i(pass_start), .pass_end_i(pass_end),
        .in_valid_i(in_valid),
        .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
        .w_re_i(w_re), .w_im_i(w_im),
        .out_valid_o(out_valid),
        .x_re_o(x_re), .x_im_o(x_im), .y_re_o(y_re), .y_im_o(y_im),
        .ovf_o(ovf), .scale_o(scale), .blk_exp_o(blk_exp)
    );

    function automatic int halve(int v, bit s);
        return s ? ((v + 1) >>> 1) : v;
    endfunction

    function automatic int rnd_clamp(longint p);
        longint r = (p + longint'(2 ** (DW - 2))) >>> (DW - 1);
        if (r > MAXV) return MAXV;
        if (r < MINV) return MINV;
        return int'(r);
    endfunction

    // Expected results per the requirements: e[0..3] = x_re, x_im, y_re, y_im
    task automatic model(input int j, input bit s, output int e[4], output bit eo);
        int ar = halve(TV[j][0], s);
        int ai = halve(TV[j][1], s);
        int br = halve(TV[j][2], s);
        int bi = halve(TV[j][3], s);
        int tr = rnd_clamp(longint'(br) * TV[j][4] - longint'(bi) * TV[j][5]);
        int ti = rnd_clamp(longint'(br) * TV[j][5] + longint'(bi) * TV[j][4]);
        e[0] = ar + tr; e[1] = ai + ti; e[2] = ar - tr; e[3] = ai - ti;
        eo = 1'b0;
        for (int i = 0; i < 4; i++) if (e[i] > MAXV || e[i] < MINV) eo = 1'b1;
    endtask

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        in_valid = 1'b0;
        a_re = '0; a_im = '0; b_re = '0; b_im = '0; w_re = '0; w_im = '0;
    endtask

    // which: 0 frame_start, 1 pass_start, 2 pass_end
    task automatic pulse(input int which);
        @(negedge clk);
        frame_start = (which == 0);
        pass_start  = (which == 1);
        pass_end    = (which == 2);
        @(negedge clk);
        frame_start = 1'b0; pass_start = 1'b0; pass_end = 1'b0;
    endtask

    // Streams rows first..first+cnt-1, one per cycle; row driven at negedge k
    // is compared at negedge k+3.
    task automatic run_rows(input int first, input int cnt, input bit s);
        for (int k = 0; k < cnt + 3; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                int j = first + k - 3;
                int e[4];
                bit eo;
                string tag;
                model(j, s, e, eo);
                tag = s ? "R6" : (j == 7) ? "R8" : (j == 8) ? "R5" : "R2";
                check("R3 out_valid", out_valid == TV[j][6][0], longint'(out_valid), longint'(TV[j][6]));
                if (TV[j][6] != 0) begin
                    bit ok = (x_re == e[0]) && (x_im == e[1]) && (y_re == e[2]) && (y_im == e[3]);
                    if (!ok) $display("FAIL %s row %0d: actual %0d %0d %0d %0d expected %0d %0d %0d %0d",
                                      tag, j, x_re, x_im, y_re, y_im, e[0], e[1], e[2], e[3]);
                    n_chk++;
                    if (!ok) n_bad++;
                    check("R4 ovf", ovf == eo, longint'(ovf), longint'(eo));
                end else begin
                    check("R4 ovf on bubble", ovf == 1'b0, longint'(ovf), 0);
                end
            end
            if (k < cnt) begin
                int j = first + k;
                a_re = DW'(TV[j][0]); a_im = DW'(TV[j][1]);
                b_re = DW'(TV[j][2]); b_im = DW'(TV[j][3]);
                w_re = DW'(TV[j][4]); w_im = DW'(TV[j][5]);
                in_valid = TV[j][6][0];
            end else begin
                drive_idle();
            end
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        frame_start = 1'b0; pass_start = 1'b0; pass_end = 1'b0;
        drive_idle();
        repeat (4) @(negedge clk);
        // R1: state while reset is held
        check("R1 out_valid in reset", out_valid == 1'b0, longint'(out_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid == 1'b0, longint'(out_valid), 0);
        check("R1 ovf", ovf == 1'b0, longint'(ovf), 0);
        check("R1 scale", scale == 1'b0, longint'(scale), 0);
        check("R1 exp", blk_exp == '0, longint'(blk_exp), 0);

        pulse(0);
        // Pass 1: ordinary rows with a bubble, unscaled (R2, R3, R4)
        pulse(1);
        run_rows(0, 7, 1'b0);
        pulse(2);
        check("R5 no overflow keeps scale off", scale == 1'b0, longint'(scale), 0);
        check("R7 exp after unscaled pass", blk_exp == 0, longint'(blk_exp), 0);

        // Pass 2: row 7 overflows and clamps (R8); row 8 stays unscaled (R5)
        pulse(1);
        run_rows(7, 2, 1'b0);
        pulse(2);
        check("R5 overflow sets scale", scale == 1'b1, longint'(scale), 1);
        check("R7 exp before scaled pass", blk_exp == 0, longint'(blk_exp), 0);

        // Pass 3: halved operands (R6); no overflow, so the record starts clean
        pulse(1);
        run_rows(0, 7, 1'b1);
        pulse(2);
        check("R5 sticky cleared at pass start", scale == 1'b0, longint'(scale), 0);
        check("R7 exp after scaled pass", blk_exp == 1, longint'(blk_exp), 1);

        // Pass 4: unscaled again, exponent must hold
        pulse(1);
        run_rows(0, 7, 1'b0);
        pulse(2);
        check("R7 exp holds on unscaled pass", blk_exp == 1, longint'(blk_exp), 1);

        // Overflow pass, then frame start clears everything (R7)
        pulse(1);
        run_rows(7, 2, 1'b0);
        pulse(2);
        check("R5 overflow sets scale again", scale == 1'b1, longint'(scale), 1);
        pulse(0);
        check("R7 frame start clears scale", scale == 1'b0, longint'(scale), 0);
        check("R7 frame start clears exp", blk_exp == 0, longint'(blk_exp), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule